// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a small processor that retires one 32-bit instruction on every rising clock edge, with no pipeline registers between fetch and register write. It understands six instructions: unsigned add, unsigned subtract, OR with a 16-bit immediate, word load, word store and branch on equal. It holds a program counter, a decoder and control unit, a 32-entry by 32-bit register file, an immediate extender, an add/subtract/OR unit with a zero flag, and separate internal instruction and data memories.

While `run` is low the core is frozen. A test port can then write either memory and read back the data memory. The usual flow is to hold `run` low after reset, load a program and its data, raise `run` for a number of cycles, lower it again and read the results out of the data memory.

Top module: `scp_core`

## Requirements
- R1: A synchronous reset, active high, sets the program counter to 0 at the next rising edge.
- R2: An instruction with opcode 0x00 and bits [10:6] equal to zero writes R[rs]+R[rt] into R[rd] when bits [5:0] are 0x21, and R[rs]-R[rt] when they are 0x23. Both wrap modulo 2^32 and never trap. The fields are rs=[25:21], rt=[20:16] and rd=[15:11].
- R3: Opcode 0x0D writes R[rs] OR the zero-extended immediate in bits [15:0] into R[rt].
- R4: Opcode 0x23 loads into R[rt] the data word at R[rs] plus the sign-extended immediate. Opcode 0x2B stores R[rt] at that address. Each memory selects a word with address bits [MEM_AW+1:2].
- R5: Opcode 0x04 sets the PC to PC+4+(sign-extended immediate << 2) when R[rs]==R[rt], and to PC+4 otherwise. Backward offsets are included.
- R6: Every instruction other than a branch advances the PC by 4. Every opcode, funct or shift-field value not listed in R2 to R5 is a no-op that changes no register and no memory word.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: While `run` is low the PC, the registers and the data memory hold their values, except for words the test port writes. The test port writes the instruction memory (`tp_imem_we`) or the data memory (`tp_dmem_we`) at word index `tp_addr`. `tp_rdata` shows the data word at `tp_addr` one edge later.
- R9: While `run` is high, exactly one instruction completes on each rising edge, a taken branch included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1: execute one instruction per cycle; 0: frozen, test port active |
| tp_imem_we | input | 1 | Test-port write strobe for instruction memory |
| tp_dmem_we | input | 1 | Test-port write strobe for data memory |
| tp_addr | input | MEM_AW | Test-port word index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Registered data-memory word at `tp_addr` |
| pc | output | 32 | Program counter register |

## Verification
The hardest states to reach from the ports are the ones where a write must not happen: a write aimed at register 0, an unknown funct or opcode, and a branch that is not taken. None of these shows up on `pc` or `tp_rdata` on its own. The test program therefore follows each of them with a store of the register that might have been corrupted. It also places a taken forward branch over two stores whose absence is then read back. A negative store/load offset and a backward self-branch exercise sign extension, and the run ends parked in a self-loop so the PC settles before the memory is read out.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU   = 6'h21;
  localparam logic [5:0] FN_SUBU   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    zero_ext;
    logic    mem_we;
    logic    mem_to_reg;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/scp_control.sv
module scp_control
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, zero_ext: 1'b0,
             mem_we: 1'b0, mem_to_reg: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_RTYPE: begin
        if (shamt == 5'd0 && (funct == FN_ADDU || funct == FN_SUBU)) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.zero_ext = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int WIDTH    = 32,
  parameter int NREG     = 32,
  parameter bit ZERO_REG = 1'b1,
  localparam int IW      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ra,
  input  logic [IW-1:0]    rb,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] regs [NREG];
  logic             wr_ok;

  generate
    if (ZERO_REG) begin : g_hardwired_zero
      assign wr_ok   = we && (waddr != '0);
      assign rdata_a = (ra == '0) ? '0 : regs[ra];
      assign rdata_b = (rb == '0) ? '0 : regs[rb];
    end else begin : g_plain
      assign wr_ok   = we;
      assign rdata_a = regs[ra];
      assign rdata_b = regs[rb];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) regs[waddr] <= wdata;
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y,
  output logic             zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/scp_mem.sv
module scp_mem #(
  parameter int WIDTH = 32,
  parameter int AW    = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tp_imem_we,
  input  logic              tp_dmem_we,
  input  logic [MEM_AW-1:0] tp_addr,
  input  logic [XLEN-1:0]   tp_wdata,
  output logic [XLEN-1:0]   tp_rdata,
  output logic [XLEN-1:0]   pc
);

  localparam int WLO = 2;
  localparam int WHI = MEM_AW + 1;

  logic            active;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic [XLEN-1:0] rs_data, rt_data, imm_ext, alu_b, alu_y, wb_data;
  logic            alu_zero;
  logic [XLEN-1:0] pc_plus4, br_target, pc_next;
  logic [MEM_AW-1:0] imem_addr, dmem_addr;
  logic            imem_we, dmem_we;
  logic [XLEN-1:0] dmem_wdata, dmem_rdata;

  assign active = run && !rst;

  // fetch
  assign imem_addr = run ? pc[WHI:WLO] : tp_addr;
  assign imem_we   = !run && !rst && tp_imem_we;

  scp_mem #(.WIDTH(XLEN), .AW(MEM_AW)) u_imem (
    .clk(clk), .we(imem_we), .addr(imem_addr), .wdata(tp_wdata), .rdata(instr)
  );

  // decode
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];

  scp_control u_ctrl (
    .opcode(instr[31:26]), .shamt(instr[10:6]), .funct(instr[5:0]), .ctrl(ctrl)
  );

  assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;

  scp_regfile #(.WIDTH(XLEN), .NREG(NREG), .ZERO_REG(1'b1)) u_rf (
    .clk(clk), .we(active && ctrl.reg_we), .waddr(dst_idx), .wdata(wb_data),
    .ra(rs_idx), .rb(rt_idx), .rdata_a(rs_data), .rdata_b(rt_data)
  );

  // execute
  assign imm_ext = ctrl.zero_ext ? {16'h0000, instr[15:0]}
                                 : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_data;

  scp_alu #(.WIDTH(XLEN)) u_alu (
    .a(rs_data), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  // memory
  assign dmem_addr  = run ? alu_y[WHI:WLO] : tp_addr;
  assign dmem_we    = !rst && (run ? ctrl.mem_we : tp_dmem_we);
  assign dmem_wdata = run ? rt_data : tp_wdata;

  scp_mem #(.WIDTH(XLEN), .AW(MEM_AW)) u_dmem (
    .clk(clk), .we(dmem_we), .addr(dmem_addr), .wdata(dmem_wdata), .rdata(dmem_rdata)
  );

  // write back
  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  // next address
  assign pc_plus4  = pc + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_next   = (ctrl.branch && alu_zero) ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (run) pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst)       tp_rdata <= '0;
    else if (!run) tp_rdata <= dmem_rdata;
  end

endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data
);

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc == '0));

  assert_beq_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (run && instr[31:26] == 6'h04 && rs_data == rt_data)
      |=> (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_data == '0));

  assert_halt_pc_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pc == $past(pc)));

  assert_one_step_R9: assert property (@(posedge clk) disable iff (rst)
    (run && instr[31:26] != 6'h04) |=> (pc == $past(pc) + 32'd4));

endmodule

bind scp_core scp_core_chk #(.XLEN(32)) u_chk (
  .clk(clk), .rst(rst), .run(run), .pc(pc), .instr(instr),
  .rs_data(rs_data), .rt_data(rt_data)
);

// File: tb/scp_core_bench.sv
`timescale 1ns/1ps
module scp_core_bench;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          tp_imem_we = 1'b0;
  logic          tp_dmem_we = 1'b0;
  logic [AW-1:0] tp_addr = '0;
  logic [31:0]   tp_wdata = '0;
  logic [31:0]   tp_rdata;
  logic [31:0]   pc;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_rf   [32];
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  scp_core #(.MEM_AW(AW), .NREG(32)) u_scp_core (
    .clk(clk), .rst(rst), .run(run), .tp_imem_we(tp_imem_we),
    .tp_dmem_we(tp_dmem_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata),
    .tp_rdata(tp_rdata), .pc(pc)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference: executes one instruction, reports its class
  task automatic model_step(output string tag);
    logic [31:0] ins, a, b, sx, zx, ea;
    ins = m_imem[m_pc[AW+1:2]];
    a   = m_rf[ins[25:21]];
    b   = m_rf[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    zx  = {16'h0, ins[15:0]};
    ea  = a + sx;
    tag = "R6";
    if (ins[31:26] == 6'h00 && ins[10:6] == 0 && ins[5:0] == 6'h21) begin
      m_rf[ins[15:11]] = a + b; tag = "R2";
    end else if (ins[31:26] == 6'h00 && ins[10:6] == 0 && ins[5:0] == 6'h23) begin
      m_rf[ins[15:11]] = a - b; tag = "R2";
    end else if (ins[31:26] == 6'h0D) begin
      m_rf[ins[20:16]] = a | zx; tag = "R3";
    end else if (ins[31:26] == 6'h23) begin
      m_rf[ins[20:16]] = m_dmem[ea[AW+1:2]]; tag = "R4";
    end else if (ins[31:26] == 6'h2B) begin
      m_dmem[ea[AW+1:2]] = b; tag = "R4";
    end
    m_rf[0] = 32'h0;
    if (ins[31:26] == 6'h04) begin
      tag = "R5";
      m_pc = (a == b) ? m_pc + 4 + {sx[29:0], 2'b00} : m_pc + 4;
    end else begin
      m_pc = m_pc + 4;
    end
  endtask

  task automatic tp_write(bit imem, int idx, logic [31:0] d);
    @(negedge clk);
    tp_addr = idx[AW-1:0]; tp_wdata = d;
    tp_imem_we = imem; tp_dmem_we = !imem;
    @(negedge clk);
    tp_imem_we = 1'b0; tp_dmem_we = 1'b0;
  endtask

  task automatic tp_read(int idx, output logic [31:0] d);
    @(negedge clk);
    tp_addr = idx[AW-1:0];
    @(negedge clk);
    d = tp_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [31:0] rd;
    for (int i = 0; i < DEPTH; i++) begin m_imem[i] = 32'h0; m_dmem[i] = 32'h0; end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    // program
    m_imem[0]  = enc_i(6'h0D, 0, 1, 16'h0005);
    m_imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
    m_imem[2]  = enc_r(1, 2, 3, 6'h21);
    m_imem[3]  = enc_r(1, 2, 4, 6'h23);
    m_imem[4]  = enc_i(6'h2B, 0, 3, 0);
    m_imem[5]  = enc_i(6'h2B, 0, 4, 4);
    m_imem[6]  = enc_i(6'h0D, 0, 0, 16'h1234);
    m_imem[7]  = enc_i(6'h2B, 0, 0, 8);
    m_imem[8]  = enc_i(6'h0D, 0, 5, 16'h0020);
    m_imem[9]  = enc_i(6'h2B, 5, 1, -4);
    m_imem[10] = enc_i(6'h23, 5, 6, -4);
    m_imem[11] = enc_i(6'h04, 6, 1, 2);
    m_imem[12] = enc_i(6'h2B, 0, 2, 20);
    m_imem[13] = enc_i(6'h2B, 0, 2, 24);
    m_imem[14] = enc_i(6'h04, 1, 2, 5);
    m_imem[15] = enc_r(6, 3, 7, 6'h21);
    m_imem[16] = enc_i(6'h2B, 0, 7, 12);
    m_imem[17] = enc_i(6'h3F, 0, 7, 16'h7777);
    m_imem[18] = enc_r(1, 1, 7, 6'h00);
    m_imem[19] = enc_i(6'h2B, 0, 7, 16);
    m_imem[20] = {6'h00, 5'd1, 5'd1, 5'd7, 5'd3, 6'h21};
    m_imem[21] = enc_i(6'h2B, 0, 7, 36);
    m_imem[22] = enc_i(6'h04, 0, 0, -1);
    m_pc = 32'h0;

    repeat (3) @(negedge clk);
    check("R1 reset pc", pc, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) tp_write(1'b1, i, m_imem[i]);
    for (int i = 0; i < DEPTH; i++) tp_write(1'b0, i, 32'h0);
    check("R8 halted pc", pc, 32'h0);

    @(negedge clk);
    run = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      model_step(tag);
      if (c == 39) run = 1'b0;
      check({tag, " R9 pc"}, pc, m_pc);
    end
    repeat (3) @(negedge clk);
    check("R8 pc frozen", pc, m_pc);

    for (int i = 0; i < 12; i++) begin
      tp_read(i, rd);
      case (i)
        0, 1, 3: check("R2 dmem", rd, m_dmem[i]);
        2:       check("R7 dmem", rd, m_dmem[i]);
        4, 9:    check("R6 dmem", rd, m_dmem[i]);
        5, 6:    check("R5 dmem", rd, m_dmem[i]);
        default: check("R4 dmem", rd, m_dmem[i]);
      endcase
    end
    check("R3 zext", m_dmem[0], 32'h00010004);

    tp_write(1'b0, 40, 32'hCAFE_F00D);
    tp_read(40, rd);
    check("R8 tp write", rd, 32'hCAFE_F00D);
    check("R8 pc after tp", pc, m_pc);

    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", pc, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule